// File: doc/BRIEF.md
# Affinity-Constrained Counter Allocator

This block hands out hardware event counters from a pool of ten. A requester presents an 8-bit event code for one cycle. The allocator looks up which counters are able to count that event. It removes the counters already in use and picks the lowest-numbered counter that remains. On the following cycle it answers with a grant that carries a 4-bit counter index, or with a fail pulse when no eligible counter is free.

Each event has its own eligibility mask, and some of these masks are irregular: a single counter, every other counter, or a band in the middle of the pool. Allocation is a greedy first fit over that mask only, never over the whole pool. A separate release port returns a counter to the pool by index. The current set of occupied counters is visible at all times as a bit vector.

Top module: `ctr_alloc`

## Requirements
- R1: After reset the occupancy vector `used_o` is all zero, and neither `gnt_valid_o` nor `fail_o` is high.
- R2: An event code with no special entry (for example 0x33) may use counters 2 to 9 only. Counters 0 and 1 are never granted to it.
- R3: Event 0x02 (cycles) may use counter 0 as well as counters 2 to 9.
- R4: Event 0x8C (all instructions) may use only counters 1 and 7.
- R5: Events 0x8D–0x90, 0x93–0x95, 0x98, 0x99, 0x9C, 0xBF–0xC1, 0xC4–0xC6, 0xC8, 0xCA and 0xCB may use only counters 5, 6 and 7.
- R6: Events 0x01, 0x96, 0x97, 0x9A, 0x9B and 0x9F may use only counter 7.
- R7: Events 0xF5, 0xF6, 0xF7 and 0xFD may use only counters 2, 4 and 6. Event 0xF8 may use counters 2 to 7.
- R8: A grant names the lowest-indexed counter that is both eligible and free. Bit `used_o[idx]` is set at the same clock edge that raises `gnt_valid_o`.
- R9: A request pulse on `req_valid_i` in cycle t gives exactly one of `gnt_valid_o` or `fail_o` in cycle t+1. A fail leaves `used_o` unchanged.
- R10: A release of an occupied counter clears its bit in `used_o` at the next clock edge.
- R11: When a release and a request arrive in the same cycle, the release is applied first, so the request may be granted the counter being freed.
- R12: A release of a counter that is already free, or of an index of 10 or above, leaves `used_o` unchanged.
- R13: Without a request in the previous cycle, `gnt_valid_o` and `fail_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Single-cycle allocation request |
| req_event_i | input | 8 | Event code of the request |
| rel_valid_i | input | 1 | Release strobe |
| rel_idx_i | input | 4 | Index of the counter to release |
| gnt_valid_o | output | 1 | Grant pulse, one cycle after a request |
| gnt_idx_o | output | 4 | Index of the granted counter |
| fail_o | output | 1 | Failure pulse, one cycle after a request |
| used_o | output | 10 | Occupancy vector, bit n set while counter n is allocated |

## Verification
The assertions take for granted that `req_valid_i` and `rel_valid_i` are known values after reset, and that a request is sampled only at a clock edge. They make no assumption about how often releases are issued or which indices they carry. The directed stimulus changes inputs only on the falling edge. It holds every request to a single cycle, and it also issues releases for free counters and for indices above the pool, so that the no-effect paths are exercised within those bounds.

// File: rtl/ctr_alloc_pkg.sv
package ctr_alloc_pkg;
  localparam int unsigned CNT_N = 10;
  localparam int unsigned EVT_W = 8;
  localparam int unsigned IDX_W = $clog2(CNT_N);

  typedef logic [CNT_N-1:0] cnt_mask_t;

  localparam cnt_mask_t MASK_DEFAULT = 10'h3FC;
  localparam cnt_mask_t MASK_CYCLE   = 10'h3FD;
  localparam cnt_mask_t MASK_INSTR   = 10'h082;
  localparam cnt_mask_t MASK_MID3    = 10'h0E0;
  localparam cnt_mask_t MASK_SEVEN   = 10'h080;
  localparam cnt_mask_t MASK_EVEN3   = 10'h054;
  localparam cnt_mask_t MASK_BAND    = 10'h0FC;

  function automatic cnt_mask_t affinity_of(input logic [EVT_W-1:0] evt);
    unique case (evt)
      8'h02:                                    return MASK_CYCLE;
      8'h8C:                                    return MASK_INSTR;
      8'h01, 8'h96, 8'h97, 8'h9A, 8'h9B, 8'h9F: return MASK_SEVEN;
      8'h8D, 8'h8E, 8'h8F, 8'h90, 8'h93, 8'h94, 8'h95,
      8'h98, 8'h99, 8'h9C, 8'hBF, 8'hC0, 8'hC1, 8'hC4,
      8'hC5, 8'hC6, 8'hC8, 8'hCA, 8'hCB:        return MASK_MID3;
      8'hF5, 8'hF6, 8'hF7, 8'hFD:               return MASK_EVEN3;
      8'hF8:                                    return MASK_BAND;
      default:                                  return MASK_DEFAULT;
    endcase
  endfunction
endpackage

// File: rtl/ctr_alloc_lut.sv
module ctr_alloc_lut
  import ctr_alloc_pkg::*;
(
  input  logic [EVT_W-1:0] evt_i,
  output cnt_mask_t        mask_o
);
  always_comb mask_o = affinity_of(evt_i);
endmodule

// File: rtl/ctr_alloc_first_fit.sv
module ctr_alloc_first_fit #(
  parameter int unsigned N = 10,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  output logic          found_o,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign onehot_o[i] = cand_i[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | cand_i[i];
  end

  assign found_o = taken[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
  end

  // nothing eligible below the pick
  always_comb begin
    if (found_o)
      AST_LOWEST_PICK: assert ((cand_i & ((N'(1) << idx_o) - N'(1))) == '0); // R8
  end
endmodule

// File: rtl/ctr_alloc_used.sv
module ctr_alloc_used #(
  parameter int unsigned N = 10,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rel_valid_i,
  input  logic [IW-1:0] rel_idx_i,
  input  logic          set_valid_i,
  input  logic [N-1:0]  set_onehot_i,
  output logic [N-1:0]  used_q_o,
  output logic [N-1:0]  used_eff_o
);
  logic [N-1:0] rel_oh;

  for (genvar i = 0; i < N; i++) begin : g_rel
    assign rel_oh[i] = rel_valid_i & (rel_idx_i == IW'(i));
  end

  // release takes effect before the same-cycle allocation
  assign used_eff_o = used_q_o & ~rel_oh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          used_q_o <= '0;
    else if (set_valid_i) used_q_o <= used_eff_o | set_onehot_i;
    else                  used_q_o <= used_eff_o;
  end

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_valid_i |=> (used_q_o & $past(set_onehot_i)) == $past(set_onehot_i)); // R8

  AST_REL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i && !set_valid_i |=> (used_q_o & $past(rel_oh)) == '0); // R10
endmodule

// File: rtl/ctr_alloc.sv
module ctr_alloc
  import ctr_alloc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [EVT_W-1:0] req_event_i,
  input  logic             rel_valid_i,
  input  logic [IDX_W-1:0] rel_idx_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic             fail_o,
  output logic [CNT_N-1:0] used_o
);
  cnt_mask_t        aff, used_eff, avail, pick_oh;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;

  ctr_alloc_lut u_lut (
    .evt_i  (req_event_i),
    .mask_o (aff)
  );

  assign avail = aff & ~used_eff;

  ctr_alloc_first_fit #(.N(CNT_N)) u_pick (
    .cand_i   (avail),
    .found_o  (pick_found),
    .onehot_o (pick_oh),
    .idx_o    (pick_idx)
  );

  ctr_alloc_used #(.N(CNT_N)) u_used (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rel_valid_i  (rel_valid_i),
    .rel_idx_i    (rel_idx_i),
    .set_valid_i  (req_valid_i & pick_found),
    .set_onehot_i (pick_oh),
    .used_q_o     (used_o),
    .used_eff_o   (used_eff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_valid_o <= 1'b0;
      gnt_idx_o   <= '0;
      fail_o      <= 1'b0;
    end else begin
      gnt_valid_o <= req_valid_i & pick_found;
      fail_o      <= req_valid_i & ~pick_found;
      if (req_valid_i & pick_found) gnt_idx_o <= pick_idx;
    end
  end

  AST_ONE_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gnt_valid_o && fail_o)); // R9

  AST_ANSWER_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o || fail_o) |-> $past(req_valid_i)); // R13

  AST_REQ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (gnt_valid_o || fail_o)); // R9

  AST_GNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> (gnt_idx_o < IDX_W'(CNT_N)) && used_o[gnt_idx_o]); // R8

  AST_FAIL_KEEPS_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !$past(rel_valid_i) |-> $stable(used_o)); // R9
endmodule

// File: tb/ctr_alloc_tb_top.sv
`timescale 1ns/1ps
module ctr_alloc_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [7:0] req_event_i = '0;
  logic       rel_valid_i = 1'b0;
  logic [3:0] rel_idx_i = '0;
  logic       gnt_valid_o, fail_o;
  logic [3:0] gnt_idx_o;
  logic [9:0] used_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ctr_alloc dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_event_i, .rel_valid_i, .rel_idx_i,
    .gnt_valid_o, .gnt_idx_o, .fail_o, .used_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // exp_idx < 0 means a fail is expected
  task automatic do_req(input string req, input logic [7:0] evt, input int exp_idx);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_event_i = evt;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req, "gnt_valid", int'(gnt_valid_o), int'(exp_idx >= 0));
    chk(req, "fail", int'(fail_o), int'(exp_idx < 0));
    if (exp_idx >= 0) chk(req, "gnt_idx", int'(gnt_idx_o), exp_idx);
  endtask

  task automatic do_rel(input logic [3:0] idx);
    @(negedge clk_i);
    rel_valid_i = 1'b1; rel_idx_i = idx;
    @(negedge clk_i);
    rel_valid_i = 1'b0;
  endtask

  task automatic free_all();
    for (int i = 0; i < 10; i++) do_rel(4'(i));
    chk("R10", "used after full release", int'(used_o), 0);
  endtask

  task automatic t_reset();
    chk("R1", "used", int'(used_o), 0);
    chk("R1", "gnt_valid", int'(gnt_valid_o), 0);
    chk("R1", "fail", int'(fail_o), 0);
  endtask

  task automatic t_default();
    for (int i = 2; i < 10; i++) do_req("R2", 8'h33, i);
    chk("R2", "used full", int'(used_o), 'h3FC);
    do_req("R9", 8'h33, -1);
    chk("R9", "used kept on fail", int'(used_o), 'h3FC);
    @(negedge clk_i);
    chk("R13", "gnt idle", int'(gnt_valid_o), 0);
    chk("R13", "fail idle", int'(fail_o), 0);
    free_all();
  endtask

  task automatic t_cycle();
    do_req("R3", 8'h02, 0);
    do_req("R3", 8'h02, 2);
    free_all();
  endtask

  task automatic t_instr();
    do_req("R4", 8'h8C, 1);
    do_req("R4", 8'h8C, 7);
    do_req("R4", 8'h8C, -1);
    free_all();
  endtask

  task automatic t_mid3();
    do_req("R5", 8'h8D, 5);
    do_req("R5", 8'hC4, 6);
    do_req("R5", 8'h95, 7);
    do_req("R5", 8'hCB, -1);
    free_all();
  endtask

  task automatic t_seven();
    do_req("R6", 8'h9F, 7);
    do_req("R6", 8'h01, -1);
    free_all();
  endtask

  task automatic t_even_band();
    do_req("R7", 8'hF5, 2);
    do_req("R7", 8'hFD, 4);
    do_req("R7", 8'hF7, 6);
    do_req("R7", 8'hF6, -1);
    do_req("R7", 8'hF8, 3);
    chk("R7", "used", int'(used_o), 'h05C);
    free_all();
  endtask

  task automatic t_lowest();
    for (int i = 2; i < 10; i++) do_req("R8", 8'h40, i);
    do_rel(4'd8);
    do_rel(4'd4);
    chk("R10", "used after release", int'(used_o), 'h2EC);
    do_req("R8", 8'h40, 4);
    do_req("R8", 8'h40, 8);
  endtask

  task automatic t_same_cycle();
    // pool 2..9 full from t_lowest
    @(negedge clk_i);
    req_valid_i = 1'b1; req_event_i = 8'h33;
    rel_valid_i = 1'b1; rel_idx_i = 4'd5;
    @(negedge clk_i);
    req_valid_i = 1'b0; rel_valid_i = 1'b0;
    chk("R11", "gnt_valid", int'(gnt_valid_o), 1);
    chk("R11", "gnt_idx", int'(gnt_idx_o), 5);
    chk("R11", "used", int'(used_o), 'h3FC);
    free_all();
  endtask

  task automatic t_ignore();
    do_req("R12", 8'h33, 2);
    do_rel(4'd3);
    chk("R12", "free release", int'(used_o), 'h004);
    do_rel(4'd12);
    chk("R12", "out of range release", int'(used_o), 'h004);
    chk("R13", "no response to release", int'(gnt_valid_o | fail_o), 0);
    free_all();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_default();
    t_cycle();
    t_instr();
    t_mid3();
    t_seven();
    t_even_band();
    t_lowest();
    t_same_cycle();
    t_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule